// File: doc/BRIEF.md
# Flash Security and JTAG Programming Gatekeeper

This block stands between the command decoder of an in-system-programming JTAG port and the controller of an on-chip flash array. Every decoded command (read, program, sector erase, full chip erase, verify, or the command that enters programming mode) is judged in the cycle it arrives. The verdict is registered and appears one clock later as a grant or a deny pulse. A granted command also produces a read or write strobe towards the flash controller.

Two nonvolatile settings steer the judgement, and both are modelled as plain inputs. The first is a security bit, latched at power-on. While it is set, only a full chip erase gets through. When that erase finishes, the bit clears. The second is a per-sector protect mask that refuses sector erases. The port itself is enabled in one of two ways. A configuration input can dedicate it permanently. Otherwise it is enabled by a one-bit enable register that the host processor writes. In register mode the system reset stops JTAG work. In dedicated mode the reset leaves JTAG work alone.

Two status pins report to the JTAG side. The first shows whether the flash is ready. The second is an error flag. Both can be switched to open-drain drive so that several devices can share one wire.

Top module: `flash_guard`

## Requirements
- R1: While the security state is set, read (op 0), program (op 1), sector erase (op 2) and verify (op 4) are denied: deny_o pulses one cycle after the command, grant_o stays 0, and neither fl_wr_o nor fl_rd_o pulses.
- R2: While secured, a full chip erase (op 3) is granted with an fl_wr_o pulse. The command that enters programming mode (op 5) is granted in any security state, with no flash strobe.
- R3: The security state loads from cfg_secure_i while por_n is low. It clears at the first clock edge where fl_busy_i is low after it has been seen high following a granted chip erase. From then on, reads are granted.
- R4: When not secured, a sector erase is denied if bit cmd_sect_i of cfg_protect_i is 1 and granted with fl_wr_o otherwise. Reads and verifies are granted with fl_rd_o, and programs are granted with fl_wr_o.
- R5: jen_rdata_o returns the enable register with only bit 0 writable (1 = port on). Bits 7:1 always read 0. The register clears while rst_n or por_n is low, and writes made during reset are lost.
- R6: With cfg_dedicated_i = 0, commands are ignored (no grant and no deny) while the enable bit is 0 or rst_n is low. With cfg_dedicated_i = 1, commands are judged whatever the state of the enable register and of rst_n.
- R7: tstat_o is 1 exactly when neither fl_busy_i nor fl_sec_wr_i is high.
- R8: A granted op 5 with od_sel_i = 1 selects open-drain mode, in which tstat_oe_o and terr_oe_o are 1 only while their pin level is 0. With od_sel_i = 0 it selects push-pull mode, in which both enables are 1.
- R9: terr_n_o goes to 0 in the cycle deny_o pulses and stays 0 until the next granted command. In register mode rst_n returns it to 1, and por_n always does.
- R10: Op codes 6 and 7 are denied with no flash strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; loads the modelled nonvolatile security bit |
| rst_n | input | 1 | System reset, active low |
| cfg_secure_i | input | 1 | Nonvolatile security setting |
| cfg_dedicated_i | input | 1 | Nonvolatile option that dedicates the JTAG port |
| cfg_protect_i | input | NUM_SECT | Per-sector erase protect mask |
| cmd_vld_i | input | 1 | Decoded command strobe |
| cmd_op_i | input | 3 | Command code |
| cmd_sect_i | input | SECT_W | Target sector |
| od_sel_i | input | 1 | Pin drive mode carried with op 5 (1 = open drain) |
| jen_wr_i | input | 1 | Enable register write strobe |
| jen_wdata_i | input | JEN_W | Enable register write data |
| jen_rdata_o | output | JEN_W | Enable register read data |
| fl_busy_i | input | 1 | Flash program or erase in progress |
| fl_sec_wr_i | input | 1 | Secondary flash write in progress |
| grant_o | output | 1 | Command accepted (one cycle after the command) |
| deny_o | output | 1 | Command refused (one cycle after the command) |
| fl_wr_o | output | 1 | Program or erase strobe to the flash controller |
| fl_rd_o | output | 1 | Read or verify strobe to the flash controller |
| secure_o | output | 1 | Current security state |
| tstat_o | output | 1 | Ready pin level (1 = ready) |
| tstat_oe_o | output | 1 | Ready pin output enable |
| terr_n_o | output | 1 | Error pin level (0 = error) |
| terr_oe_o | output | 1 | Error pin output enable |

## Verification
The assertions assume that fl_busy_i rises only after the flash controller has received a write strobe. They also assume the configuration inputs change only between commands. The stimulus respects both: it raises the busy flag only once a chip erase has been granted, and it changes the mask, the security setting and the port mode only on idle cycles. The assertions further assume that por_n is asserted at start-up before any clocked check counts. The bench holds it low over the first edges so that the power-on load of the security state is in place first.

// File: rtl/fg_pkg.sv
package fg_pkg;
   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_PROG   = 3'd1,
      OP_SERASE = 3'd2,
      OP_CERASE = 3'd3,
      OP_VERIFY = 3'd4,
      OP_ISC    = 3'd5,
      OP_RSV6   = 3'd6,
      OP_RSV7   = 3'd7
   } fg_op_e;

   typedef struct packed {
      logic grant;
      logic deny;
      logic wr;
      logic rd;
      logic arm;
      logic isc;
   } fg_verdict_t;
endpackage

// File: rtl/fg_cmd_judge.sv
module fg_cmd_judge
   import fg_pkg::*;
#(
   parameter int NUM_SECT = 8,
   parameter int SECT_W   = 3
) (
   input  logic                vld_i,
   input  logic [2:0]          op_i,
   input  logic [SECT_W-1:0]   sect_i,
   input  logic                secure_i,
   input  logic                port_en_i,
   input  logic [NUM_SECT-1:0] protect_i,
   output fg_verdict_t         verdict_o
);
   localparam int SPAN = 1 << SECT_W;

   logic [SPAN-1:0] prot_ext;
   fg_op_e          op;

   // sectors beyond the array are treated as protected
   generate
      if (SPAN > NUM_SECT) begin : g_pad
         assign prot_ext = {{(SPAN-NUM_SECT){1'b1}}, protect_i};
      end else begin : g_nopad
         assign prot_ext = protect_i;
      end
   endgenerate

   assign op = fg_op_e'(op_i);

   always_comb begin
      verdict_o = '0;
      if (vld_i && port_en_i) begin
         unique case (op)
            OP_READ, OP_VERIFY: begin
               verdict_o.deny  = secure_i;
               verdict_o.grant = !secure_i;
               verdict_o.rd    = !secure_i;
            end
            OP_PROG: begin
               verdict_o.deny  = secure_i;
               verdict_o.grant = !secure_i;
               verdict_o.wr    = !secure_i;
            end
            OP_SERASE: begin
               verdict_o.deny  = secure_i || prot_ext[sect_i];
               verdict_o.grant = !(secure_i || prot_ext[sect_i]);
               verdict_o.wr    = !(secure_i || prot_ext[sect_i]);
            end
            OP_CERASE: begin
               verdict_o.grant = 1'b1;
               verdict_o.wr    = 1'b1;
               verdict_o.arm   = 1'b1;
            end
            OP_ISC: begin
               verdict_o.grant = 1'b1;
               verdict_o.isc   = 1'b1;
            end
            default: verdict_o.deny = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/fg_secure_track.sv
module fg_secure_track (
   input  logic clk,
   input  logic por_n,
   input  logic cfg_secure_i,
   input  logic arm_i,
   input  logic busy_i,
   output logic secure_o
);
   logic secure_q, arm_q, seen_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         secure_q <= cfg_secure_i;
         arm_q    <= 1'b0;
         seen_q   <= 1'b0;
      end else if (seen_q && !busy_i) begin
         secure_q <= 1'b0;
         arm_q    <= 1'b0;
         seen_q   <= 1'b0;
      end else begin
         if (arm_i)            arm_q  <= 1'b1;
         if (arm_q && busy_i)  seen_q <= 1'b1;
      end
   end

   assign secure_o = secure_q;

   // R3: security clears only after an erase has been seen busy and then idle
   p_clear_after_erase_r3: assert property (@(posedge clk) disable iff (!por_n)
      $fell(secure_q) |-> $past(seen_q && !busy_i));
endmodule

// File: rtl/fg_pin_drive.sv
module fg_pin_drive #(
   parameter bit OD_SUPPORT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic isc_i,
   input  logic od_req_i,
   input  logic busy_i,
   input  logic sec_wr_i,
   input  logic err_i,
   output logic tstat_o,
   output logic tstat_oe_o,
   output logic terr_n_o,
   output logic terr_oe_o
);
   logic od;

   generate
      if (OD_SUPPORT) begin : g_od
         logic od_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     od_q <= 1'b0;
            else if (isc_i) od_q <= od_req_i;
         end
         assign od = od_q;
      end else begin : g_pp
         logic unused_req;
         assign unused_req = isc_i ^ od_req_i;
         assign od = 1'b0;
      end
   endgenerate

   assign tstat_o    = !(busy_i || sec_wr_i);
   assign terr_n_o   = !err_i;
   assign tstat_oe_o = od ? !tstat_o  : 1'b1;
   assign terr_oe_o  = od ? !terr_n_o : 1'b1;

   // R8: open-drain mode never drives a pin high
   p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      od |-> !(tstat_oe_o && tstat_o) && !(terr_oe_o && terr_n_o));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int  NUM_SECT   = 8,
   parameter int  JEN_W      = 8,
   parameter bit  OD_SUPPORT = 1'b1,
   localparam int SECT_W     = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
   input  logic                clk,
   input  logic                por_n,
   input  logic                rst_n,
   input  logic                cfg_secure_i,
   input  logic                cfg_dedicated_i,
   input  logic [NUM_SECT-1:0] cfg_protect_i,
   input  logic                cmd_vld_i,
   input  logic [2:0]          cmd_op_i,
   input  logic [SECT_W-1:0]   cmd_sect_i,
   input  logic                od_sel_i,
   input  logic                jen_wr_i,
   input  logic [JEN_W-1:0]    jen_wdata_i,
   output logic [JEN_W-1:0]    jen_rdata_o,
   input  logic                fl_busy_i,
   input  logic                fl_sec_wr_i,
   output logic                grant_o,
   output logic                deny_o,
   output logic                fl_wr_o,
   output logic                fl_rd_o,
   output logic                secure_o,
   output logic                tstat_o,
   output logic                tstat_oe_o,
   output logic                terr_n_o,
   output logic                terr_oe_o
);
   localparam logic [JEN_W-1:0] JEN_MASK = JEN_W'(1);

   initial begin
      assert (NUM_SECT >= 1) else $error("NUM_SECT must be at least 1");
      assert (JEN_W >= 1)    else $error("JEN_W must be at least 1");
   end

   logic              jen_rst_n, jtag_rst_n, port_en, secure, terr_q;
   logic [JEN_W-1:0]  jen_q;
   fg_verdict_t       verdict, verdict_q;

   assign jen_rst_n  = por_n & rst_n;
   // dedicated port: the system reset does not reach JTAG state
   assign jtag_rst_n = por_n & (rst_n | cfg_dedicated_i);

   always_ff @(posedge clk or negedge jen_rst_n) begin
      if (!jen_rst_n)    jen_q <= '0;
      else if (jen_wr_i) jen_q <= jen_wdata_i & JEN_MASK;
   end
   assign jen_rdata_o = jen_q;

   assign port_en = cfg_dedicated_i | (jen_q[0] & rst_n);

   fg_cmd_judge #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) judge_i (
      .vld_i     (cmd_vld_i),
      .op_i      (cmd_op_i),
      .sect_i    (cmd_sect_i),
      .secure_i  (secure),
      .port_en_i (port_en),
      .protect_i (cfg_protect_i),
      .verdict_o (verdict)
   );

   fg_secure_track sec_i (
      .clk          (clk),
      .por_n        (por_n),
      .cfg_secure_i (cfg_secure_i),
      .arm_i        (verdict.arm),
      .busy_i       (fl_busy_i),
      .secure_o     (secure)
   );

   always_ff @(posedge clk or negedge jtag_rst_n) begin
      if (!jtag_rst_n) begin
         verdict_q <= '0;
         terr_q    <= 1'b0;
      end else begin
         verdict_q <= verdict;
         if (verdict.deny)       terr_q <= 1'b1;
         else if (verdict.grant) terr_q <= 1'b0;
      end
   end

   fg_pin_drive #(.OD_SUPPORT(OD_SUPPORT)) pins_i (
      .clk        (clk),
      .rst_n      (jtag_rst_n),
      .isc_i      (verdict.isc),
      .od_req_i   (od_sel_i),
      .busy_i     (fl_busy_i),
      .sec_wr_i   (fl_sec_wr_i),
      .err_i      (terr_q),
      .tstat_o    (tstat_o),
      .tstat_oe_o (tstat_oe_o),
      .terr_n_o   (terr_n_o),
      .terr_oe_o  (terr_oe_o)
   );

   assign grant_o  = verdict_q.grant;
   assign deny_o   = verdict_q.deny;
   assign fl_wr_o  = verdict_q.wr;
   assign fl_rd_o  = verdict_q.rd;
   assign secure_o = secure;

   // R1, R10: a refused command never strobes the flash
   p_deny_no_strobe_r1: assert property (@(posedge clk) disable iff (!por_n)
      deny_o |-> !fl_wr_o && !fl_rd_o && !grant_o);
   // R1: flash contents are never read out of a secured part
   p_no_read_secured_r1: assert property (@(posedge clk) disable iff (!por_n)
      fl_rd_o |-> $past(!secure));
   // R6: register-enabled port is silent while the system reset is held
   p_reset_blocks_r6: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && !cfg_dedicated_i) |-> !grant_o && !deny_o);
   // R9: the error flag only rises together with a deny
   p_terr_rise_r9: assert property (@(posedge clk) disable iff (!jtag_rst_n)
      $fell(terr_n_o) |-> deny_o);
endmodule

// File: tb/flash_guard_tb_top.sv
module flash_guard_tb_top;
   localparam int CLK_P = 10;
   localparam int NV    = 8;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0;
   logic       cfg_secure = 1'b0, cfg_ded = 1'b1;
   logic [7:0] cfg_prot = 8'h24;
   logic       cmd_vld = 1'b0, od_sel = 1'b0, jen_wr = 1'b0;
   logic [2:0] cmd_op = '0, cmd_sect = '0;
   logic [7:0] jen_wdata = '0, jen_rdata;
   logic       fl_busy = 1'b0, fl_sec_wr = 1'b0;
   logic       grant, deny, fl_wr, fl_rd, secure, tstat, tstat_oe, terr_n, terr_oe;

   int checks = 0, errors = 0;

   always #(CLK_P/2) clk = ~clk;

   flash_guard dut_i (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_secure_i(cfg_secure),
      .cfg_dedicated_i(cfg_ded), .cfg_protect_i(cfg_prot), .cmd_vld_i(cmd_vld),
      .cmd_op_i(cmd_op), .cmd_sect_i(cmd_sect), .od_sel_i(od_sel),
      .jen_wr_i(jen_wr), .jen_wdata_i(jen_wdata), .jen_rdata_o(jen_rdata),
      .fl_busy_i(fl_busy), .fl_sec_wr_i(fl_sec_wr), .grant_o(grant), .deny_o(deny),
      .fl_wr_o(fl_wr), .fl_rd_o(fl_rd), .secure_o(secure), .tstat_o(tstat),
      .tstat_oe_o(tstat_oe), .terr_n_o(terr_n), .terr_oe_o(terr_oe)
   );

   // {op, sector, grant, deny, wr, rd, terr_n}; mask 0x24 protects sectors 2 and 5
   localparam logic [10:0] VEC [NV] = '{
      {3'd0, 3'd0, 5'b10011},
      {3'd1, 3'd3, 5'b10101},
      {3'd2, 3'd2, 5'b01000},
      {3'd2, 3'd5, 5'b01000},
      {3'd2, 3'd1, 5'b10101},
      {3'd6, 3'd0, 5'b01000},
      {3'd4, 3'd4, 5'b10011},
      {3'd2, 3'd7, 5'b10101}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [2:0] op, input logic [2:0] sect, input logic od);
      @(negedge clk);
      cmd_vld = 1'b1; cmd_op = op; cmd_sect = sect; od_sel = od;
      @(negedge clk);
      cmd_vld = 1'b0;
   endtask

   task automatic jen_write(input logic [7:0] d);
      @(negedge clk);
      jen_wr = 1'b1; jen_wdata = d;
      @(negedge clk);
      jen_wr = 1'b0;
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_P * 20000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R9 reset terr_n", terr_n, 1);
      chk("R7 reset tstat", tstat, 1);
      chk("R5 reset jen", jen_rdata, 0);
      chk("R1 reset grant/deny", {grant, deny}, 0);

      // R4 R10: table of verdicts on an unsecured part
      for (int i = 0; i < NV; i++) begin
         do_cmd(VEC[i][10:8], VEC[i][7:5], 1'b0);
         chk($sformatf("R4 vec %0d", i), {grant, deny, fl_wr, fl_rd, terr_n}, VEC[i][4:0]);
      end

      // R1 R2 R3: secured part
      @(negedge clk);
      cfg_secure = 1'b1; por_n = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      chk("R3 secure loaded", secure, 1);
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R1 secured read", {grant, deny, fl_wr, fl_rd, terr_n}, 5'b01000);
      do_cmd(3'd1, 3'd0, 1'b0);
      chk("R1 secured program", {grant, deny, fl_wr, fl_rd}, 4'b0100);
      do_cmd(3'd4, 3'd0, 1'b0);
      chk("R1 secured verify", {grant, deny, fl_wr, fl_rd}, 4'b0100);
      do_cmd(3'd2, 3'd1, 1'b0);
      chk("R1 secured sector erase", {grant, deny, fl_wr, fl_rd}, 4'b0100);
      do_cmd(3'd3, 3'd0, 1'b0);
      chk("R2 chip erase granted", {grant, deny, fl_wr, fl_rd, terr_n}, 5'b10101);
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R3 still secured before erase ends", {grant, deny}, 2'b01);
      fl_busy = 1'b1;
      @(negedge clk);
      chk("R7 tstat low while busy", tstat, 0);
      chk("R3 secure held while busy", secure, 1);
      repeat (3) @(negedge clk);
      fl_busy = 1'b0;
      @(negedge clk);
      chk("R3 secure cleared", secure, 0);
      chk("R7 tstat high when idle", tstat, 1);
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R3 read after erase", {grant, deny, fl_rd}, 3'b101);

      // R7 R8: status pins and drive mode
      fl_sec_wr = 1'b1;
      @(negedge clk);
      chk("R7 tstat low on secondary write", tstat, 0);
      fl_sec_wr = 1'b0;
      do_cmd(3'd5, 3'd0, 1'b1);
      chk("R2 isc granted", {grant, deny, fl_wr, fl_rd}, 4'b1000);
      chk("R8 od idle enables", {tstat_oe, terr_oe}, 2'b00);
      fl_sec_wr = 1'b1;
      @(negedge clk);
      chk("R8 od drives tstat low", {tstat, tstat_oe}, 2'b01);
      fl_sec_wr = 1'b0;
      do_cmd(3'd2, 3'd2, 1'b0);
      chk("R8 od drives terr low", {terr_n, terr_oe}, 2'b01);
      do_cmd(3'd5, 3'd0, 1'b0);
      chk("R8 push-pull enables", {tstat_oe, terr_oe, terr_n}, 3'b111);

      // R5 R6 R9: register-enabled port
      @(negedge clk);
      cfg_ded = 1'b0;
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R6 disabled port ignores", {grant, deny}, 2'b00);
      jen_write(8'hFF);
      chk("R5 only bit 0 kept", jen_rdata, 8'h01);
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R6 enabled port grants", {grant, fl_rd}, 2'b11);
      do_cmd(3'd2, 3'd5, 1'b0);
      chk("R9 deny sets terr", terr_n, 0);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 reset clears terr", terr_n, 1);
      chk("R5 reset clears jen", jen_rdata, 0);
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R6 reset blocks register port", {grant, deny}, 2'b00);
      jen_write(8'h01);
      chk("R5 write lost in reset", jen_rdata, 0);
      cfg_ded = 1'b1;
      do_cmd(3'd0, 3'd0, 1'b0);
      chk("R6 dedicated ignores reset", {grant, fl_rd}, 2'b11);
      do_cmd(3'd7, 3'd0, 1'b0);
      chk("R10 op 7 denied", {grant, deny, fl_wr, fl_rd}, 4'b0100);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule